// File: doc/BRIEF.md
# Interrupt Trigger Sense and Pending Flags

This block sits between a set of raw interrupt lines and a downstream request controller. It keeps one pending flag per source and decides, from each source's sense mode, when a line change raises or drops that flag. A source can be level sensitive, or it can latch a falling, rising or either-direction edge. Each line passes through a two-flop synchroniser. A per-source copy of the previous synchronised level is kept for edge detection and is refreshed every cycle in every mode.

Two registered per-source pulses go to the downstream controller. `issue` marks the cycle in which the source newly asks for service. `withdraw` marks the cycle in which a level source's line drops while that source is the request the controller currently holds. The controller names that request on `own_valid`/`own_id`. It acknowledges a taken request with `ack_valid`/`ack_id`.

A byte-wide register port gives software two things. It can read or clear the flags, and it can program the sense mode of the external-pin sources. Sources below `PIN_BASE` keep the mode they get at reset. All pins are plain strobes or levels, sampled every cycle. Nothing is buffered, and there is no back-pressure on any side.

Top module: `irq_sense_flags`

## Requirements
- R1: After reset, every source whose bit is set in `LEVEL_INIT` is in level mode. Every other source is in rising-edge mode. All flags are 0. Mode encodings are 2'b00 level, 2'b01 falling, 2'b10 rising, 2'b11 either edge.
- R2: A line change is seen through two synchroniser flops. If the line changes just after clock edge c, the flag and the `issue` pulse appear after edge c+3.
- R3: In level mode the flag follows the synchronised line. `issue` pulses for one cycle when the flag goes from 0 to 1.
- R4: When a level-mode flag clears because its line dropped, `withdraw` pulses in that same cycle, but only if `own_valid` is high and `own_id` equals that source.
- R5: In rising mode only a 0-to-1 transition sets the flag and pulses `issue`.
- R6: In falling mode only a 1-to-0 transition sets the flag and pulses `issue`.
- R7: In either-edge mode both transitions set the flag and pulse `issue`.
- R8: An edge-mode flag stays set after its line returns, until software or an acknowledge clears it.
- R9: A register write of 0x00 to a source's flag byte clears that flag only for edge-mode sources. A write of any other value has no effect. A write to a level-mode source's flag has no effect.
- R10: An acknowledge (`ack_valid` with `ack_id`) clears an edge-mode flag. It leaves a level-mode flag unchanged.
- R11: The address bit `ADDR_W-1` selects the region. When it is 0, offset n reads the flag of source n in bit 0, with bits 7:1 zero. When it is 1, offset p reads and writes the mode of source `PIN_BASE`+p in bits 3:2, with all other bits zero. Offsets beyond the implemented sources or pins read 0.
- R12: If a new selected edge and a clear (software or acknowledge) land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt lines, asynchronous |
| ack_valid | input | 1 | Acknowledge strobe from the request controller |
| ack_id | input | $clog2(NUM_SRC) | Source being acknowledged |
| own_valid | input | 1 | Controller currently holds a request |
| own_id | input | $clog2(NUM_SRC) | Source of the held request |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Register write strobe |
| bus_rdata | output | 8 | Register read data (combinational from address) |
| issue | output | NUM_SRC | One-cycle new-request pulse per source |
| withdraw | output | NUM_SRC | One-cycle request-withdrawn pulse per source |

## Verification
The bench targets the exact cycle of the first `issue` after a line change. A design with one synchroniser flop too many or too few would report it a cycle off. It targets the three edge modes against the wrong transition: a mode decoded wrongly would pulse on the return edge, or would miss the selected edge. It checks that clears and acknowledges are ignored on level sources. A design that cleared them would drop a still-asserted request, or would skip the `withdraw` that the held-request comparison should produce. It lands a clear on the very cycle a fresh edge arrives, where letting the clear win would lose an interrupt. It also checks that mode writes keep only bits 3:2.

// File: rtl/sense_pkg.sv
package sense_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_FALL  = 2'b01,
    SENSE_RISE  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;

  localparam int MODE_LSB = 2;

  // Edge qualifier for the non-level modes.
  function automatic logic edge_seen(sense_e m, logic now_lvl, logic was_lvl);
    unique case (m)
      SENSE_FALL: edge_seen = was_lvl & ~now_lvl;
      SENSE_RISE: edge_seen = ~was_lvl & now_lvl;
      SENSE_BOTH: edge_seen = was_lvl ^ now_lvl;
      default:    edge_seen = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/src_onehot.sv
module src_onehot #(
  parameter int N  = 72,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [IW-1:0] id,
  output logic [N-1:0]  hot
);

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hot[i] = en && (id == IW'(i));
  end

  // R10
  hot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hot));

endmodule

// File: rtl/sense_cell.sv
module sense_cell
  import sense_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode_i,
  input  logic   line_i,
  input  logic   sw_clr_i,
  input  logic   ack_i,
  input  logic   own_i,
  output logic   flag_o,
  output logic   issue_o,
  output logic   withdraw_o
);

  logic sync1_q, sync2_q, prev_q;
  logic flag_q, issue_q, wd_q;
  logic flag_d, issue_d, wd_d;
  logic is_lvl, hit;

  assign is_lvl = (mode_i == SENSE_LEVEL);
  assign hit    = edge_seen(mode_i, sync2_q, prev_q);

  always_comb begin
    if (is_lvl) begin
      flag_d  = sync2_q;
      issue_d = sync2_q & ~flag_q;
      wd_d    = ~sync2_q & flag_q & own_i;
    end else begin
      flag_d  = hit | (flag_q & ~sw_clr_i & ~ack_i);
      issue_d = hit;
      wd_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      flag_q  <= 1'b0;
      issue_q <= 1'b0;
      wd_q    <= 1'b0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      flag_q  <= flag_d;
      issue_q <= issue_d;
      wd_q    <= wd_d;
    end
  end

  assign flag_o     = flag_q;
  assign issue_o    = issue_q;
  assign withdraw_o = wd_q;

  // R3
  lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_lvl) |-> (flag_q == $past(sync2_q)));

  // R3
  rise_has_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> issue_q);

  // R4
  wd_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_q |-> (!flag_q && $past(flag_q) && $past(own_i)));

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!is_lvl && flag_q && !sw_clr_i && !ack_i) |-> flag_q);

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!is_lvl && hit) |-> flag_q);

endmodule

// File: rtl/sense_regs.sv
module sense_regs
  import sense_pkg::*;
#(
  parameter int NUM_SRC  = 72,
  parameter int PIN_BASE = 64,
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 9,
  parameter logic [NUM_PINS-1:0] PIN_LEVEL = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [7:0]               bus_wdata,
  input  logic                     bus_we,
  input  logic [NUM_SRC-1:0]       flags_i,
  output logic [NUM_SRC-1:0]       clr_o,
  output logic [NUM_PINS-1:0][1:0] pin_mode_o,
  output logic [7:0]               bus_rdata
);

  localparam int OFF_W = ADDR_W - 1;

  logic             ctrl_sel;
  logic [OFF_W-1:0] off;
  logic [NUM_PINS-1:0]       mode_we;
  logic [NUM_PINS-1:0][1:0]  pin_mode_q;

  assign ctrl_sel = bus_addr[ADDR_W-1];
  assign off      = bus_addr[OFF_W-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_o[i] = bus_we && !ctrl_sel && (off == OFF_W'(i)) && (bus_wdata == 8'h00);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign mode_we[p] = bus_we && ctrl_sel && (off == OFF_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pin_mode_q[p] <= PIN_LEVEL[p] ? SENSE_LEVEL : SENSE_RISE;
      else if (mode_we[p])
        pin_mode_q[p] <= bus_wdata[MODE_LSB+1:MODE_LSB];
    end
  end

  assign pin_mode_o = pin_mode_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (!ctrl_sel) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (off == OFF_W'(i)) bus_rdata[0] = flags_i[i];
    end else begin
      for (int p = 0; p < NUM_PINS; p++)
        if (off == OFF_W'(p)) bus_rdata[MODE_LSB+1:MODE_LSB] = pin_mode_q[p];
    end
  end

  // R9
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));

  // R11
  flag_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_sel |-> (bus_rdata[7:1] == 7'd0));

  // R11
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bus_we) |-> $stable(pin_mode_q));

endmodule

// File: rtl/irq_sense_flags.sv
module irq_sense_flags
  import sense_pkg::*;
#(
  parameter int NUM_SRC  = 72,
  parameter int PIN_BASE = 64,
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 9,
  parameter int ID_W     = $clog2(NUM_SRC),
  parameter logic [NUM_SRC-1:0] LEVEL_INIT = 72'h03_0000_0000_0000_0008
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               own_valid,
  input  logic [ID_W-1:0]    own_id,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_we,
  output logic [7:0]         bus_rdata,
  output logic [NUM_SRC-1:0] issue,
  output logic [NUM_SRC-1:0] withdraw
);

  localparam logic [NUM_PINS-1:0] PIN_LEVEL = LEVEL_INIT[PIN_BASE +: NUM_PINS];

  logic [NUM_SRC-1:0]       ack_hot, own_hot, clr_vec, flags;
  logic [NUM_PINS-1:0][1:0] pin_mode;
  sense_e                   mode_src [NUM_SRC];

  src_onehot #(.N(NUM_SRC), .IW(ID_W)) u_ack_dec (
    .clk(clk), .rst_n(rst_n), .en(ack_valid), .id(ack_id), .hot(ack_hot)
  );

  src_onehot #(.N(NUM_SRC), .IW(ID_W)) u_own_dec (
    .clk(clk), .rst_n(rst_n), .en(own_valid), .id(own_id), .hot(own_hot)
  );

  sense_regs #(
    .NUM_SRC(NUM_SRC), .PIN_BASE(PIN_BASE), .NUM_PINS(NUM_PINS),
    .ADDR_W(ADDR_W), .PIN_LEVEL(PIN_LEVEL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .flags_i(flags), .clr_o(clr_vec), .pin_mode_o(pin_mode),
    .bus_rdata(bus_rdata)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i >= PIN_BASE && i < PIN_BASE + NUM_PINS) begin : g_pin
      assign mode_src[i] = sense_e'(pin_mode[i-PIN_BASE]);
    end else begin : g_fix
      assign mode_src[i] = LEVEL_INIT[i] ? SENSE_LEVEL : SENSE_RISE;
    end

    sense_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .mode_i(mode_src[i]), .line_i(irq_in[i]),
      .sw_clr_i(clr_vec[i]), .ack_i(ack_hot[i]), .own_i(own_hot[i]),
      .flag_o(flags[i]), .issue_o(issue[i]), .withdraw_o(withdraw[i])
    );
  end

endmodule

// File: tb/irq_sense_flags_test.sv
module irq_sense_flags_test;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 72;
  localparam int CTRL = 256;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_in = '0;
  logic            ack_valid = 1'b0;
  logic [6:0]      ack_id = '0;
  logic            own_valid = 1'b0;
  logic [6:0]      own_id = '0;
  logic [8:0]      bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic            bus_we = 1'b0;
  logic [7:0]      bus_rdata;
  logic [NSRC-1:0] issue, withdraw;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct { int kind; int src; int at; string tag; } exp_t;
  exp_t q[$];

  irq_sense_flags uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .own_valid(own_valid), .own_id(own_id),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .issue(issue), .withdraw(withdraw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // kind 0 = issue, kind 1 = withdraw
  task automatic expect_ev(int kind, int src, int at, string tag);
    q.push_back('{kind, src, at, tag});
  endtask

  task automatic compare_ev(int kind, int src);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R2 unexpected event kind=%0d src=%0d cyc=%0d, expected none", kind, src, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.src != src || e.at != cyc) begin
        errors++;
        $display("FAIL %s event kind=%0d src=%0d cyc=%0d, expected kind=%0d src=%0d cyc=%0d",
                 e.tag, kind, src, cyc, e.kind, e.src, e.at);
      end
    end
  endtask

  // monitor: pops expectations as pulses appear
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NSRC; i++) if (issue[i]) compare_ev(0, i);
      for (int i = 0; i < NSRC; i++) if (withdraw[i]) compare_ev(1, i);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    bus_addr = a[8:0]; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ack(int s);
    ack_id = s[6:0]; ack_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic rd(int a, logic [7:0] exp, string tag);
    bus_addr = a[8:0];
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr=0x%0h got 0x%02h expected 0x%02h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic line(int s, logic v);
    irq_in[s] = v;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset modes and flags
    rd(CTRL + 0, 8'h00, "R1");
    rd(CTRL + 1, 8'h00, "R1");
    rd(CTRL + 2, 8'h08, "R1");
    rd(3, 8'h00, "R1");

    // R5 / R2 rising source 10, cycle-exact
    line(10, 1); expect_ev(0, 10, cyc + 3, "R5");
    step(2); rd(10, 8'h00, "R2");
    step(1); rd(10, 8'h01, "R2");
    line(10, 0); step(5);
    rd(10, 8'h01, "R8");

    // R9 software clear of edge flag
    wr(10, 8'h05); rd(10, 8'h01, "R9");
    wr(10, 8'h00); rd(10, 8'h00, "R9");

    // R3 / R4 level source 3, held as outstanding
    own_valid = 1'b1; own_id = 7'd3;
    line(3, 1); expect_ev(0, 3, cyc + 3, "R3");
    step(4); rd(3, 8'h01, "R3");
    wr(3, 8'h00); rd(3, 8'h01, "R9");
    ack(3); rd(3, 8'h01, "R10");
    line(3, 0); expect_ev(1, 3, cyc + 3, "R4");
    step(4); rd(3, 8'h00, "R3");

    // R4 no withdraw when another source is held
    own_id = 7'd5;
    line(3, 1); expect_ev(0, 3, cyc + 3, "R3");
    step(4);
    line(3, 0); step(4);
    rd(3, 8'h00, "R4");
    own_valid = 1'b0;

    // R11 / R6 pin 2 (source 66) to falling
    wr(CTRL + 2, 8'h04); rd(CTRL + 2, 8'h04, "R11");
    wr(CTRL + 2, 8'hF7); rd(CTRL + 2, 8'h04, "R11");
    line(66, 1); step(4); rd(66, 8'h00, "R6");
    line(66, 0); expect_ev(0, 66, cyc + 3, "R6");
    step(4); rd(66, 8'h01, "R6");
    ack(66); rd(66, 8'h00, "R10");

    // R7 either edge
    wr(CTRL + 2, 8'h0C);
    line(66, 1); expect_ev(0, 66, cyc + 3, "R7");
    step(4); rd(66, 8'h01, "R7");
    wr(66, 8'h00); rd(66, 8'h00, "R9");
    line(66, 0); expect_ev(0, 66, cyc + 3, "R7");
    step(4); rd(66, 8'h01, "R7");
    wr(66, 8'h00);

    // R12 clear lands on the edge cycle
    line(10, 1); expect_ev(0, 10, cyc + 3, "R12");
    step(2); wr(10, 8'h00);
    rd(10, 8'h01, "R12");
    line(10, 0); step(3);

    // R11 pin 0 to rising, unmapped offsets
    wr(CTRL + 0, 8'h08); rd(CTRL + 0, 8'h08, "R11");
    line(64, 1); expect_ev(0, 64, cyc + 3, "R5");
    step(4); rd(64, 8'h01, "R5");
    rd(200, 8'h00, "R11");
    rd(CTRL + 20, 8'h00, "R11");

    step(6);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++; errors++;
      $display("FAIL %s missing event kind=%0d src=%0d, expected at cyc=%0d", e.tag, e.kind, e.src, e.at);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule